// File: doc/BRIEF.md
# Two-Compare PWM Timer

This block is a 16-bit up-counting timer that produces a pulse-width modulated waveform on one output pin. The system clock is divided by 2, 4 or 8 to make the timer tick. Two compare registers set the waveform. On a match with the first, the pin takes the first level bit. On a match with the second, the pin takes the second level bit and the counter reloads to FFFCh. Because of that reload, one period lasts the second compare value plus five ticks.

Software reaches the block through a byte-wide register port: two control bytes, a status byte, four compare bytes and the low byte of a capture register. Each period-end match sets a capture flag and latches the counter into the capture register. The flag can raise an interrupt request. It is cleared by a read of the status byte followed by a read of the capture low byte. A compare register is split over two bytes, so writing its high byte disarms that compare until its low byte is written.

Top module: `pwm_timer`

## Requirements
- R1: After reset, `pwm_o` and `irq_o` are 0, the counter holds FFFFh minus 3, and the control byte (address 0), clock byte (address 1) and status byte (address 2) all read 0.
- R2: Register addresses are: 0 control (bit0 level-A, bit1 level-B, bit2 pin enable, bit3 PWM enable, bit4 one-pulse enable, bit5 capture interrupt enable), 1 clock select (bits 1:0), 2 status (bit0 capture flag), 3/4 compare-A high/low, 5/6 compare-B high/low, 7 capture low byte. Control, clock and compare bytes read back what was written.
- R3: The timer ticks once every 2, 4 or 8 system clocks for clock select 0, 1, or 2/3 respectively, and never on two consecutive clocks.
- R4: In PWM mode a tick on which the counter equals compare-B reloads the counter to FFFCh, so the output period is (compare-B + 5) ticks.
- R5: In PWM mode the pin takes level-A on a compare-A match and level-B on a compare-B match; with level-A = 1 and level-B = 0 the high time is (compare-B − compare-A) ticks.
- R6: With level-A equal to level-B the pin settles at that level and does not toggle.
- R7: With the pin enable bit clear, `pwm_o` stays 0 while PWM runs.
- R8: Writing a compare high byte disarms that compare: no match and no reload occur until its low byte is written. After the low byte is written, the new value is used.
- R9: A compare-B match in PWM mode sets the capture flag and latches the counter, so the capture low byte equals the low byte of compare-B.
- R10: `irq_o` is high exactly when the capture flag is set, capture interrupts are enabled and `int_mask_i` is 0.
- R11: The capture flag clears only when a read of the capture low byte follows a status read that saw the flag set. A capture read alone leaves it set.
- R12: Setting one-pulse enable together with PWM enable leaves the PWM period unchanged.
- R13: With PWM disabled the counter runs freely, the pin holds its level and the capture flag is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rd_en_i | input | 1 | Register read strobe (drives read side effects) |
| rdata_o | output | 8 | Register read data for `addr_i` |
| int_mask_i | input | 1 | Global interrupt mask, 1 blocks `irq_o` |
| pwm_o | output | 1 | Compare output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: byte-wide data, which gives a 16-bit counter, and a 3-bit prescaler, which allows division by 2, 4 and 8. With small compare values, a full reload cycle through FFFCh..FFFFh and zero takes only a few hundred clocks. Many periods under random compare and prescale settings therefore fit in the run, and the offset of five ticks is measured directly from edge-to-edge times on the pin. The inhibit case moves compare-B from a small value to 200 while the counter sits between them. This shows the held-off reload and the adoption of the new period without waiting for a 16-bit wrap.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_CLK  = 3'd1,
    A_STAT = 3'd2,
    A_C1H  = 3'd3,
    A_C1L  = 3'd4,
    A_C2H  = 3'd5,
    A_C2L  = 3'd6,
    A_CAPL = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic cap_ie;
    logic opm_en;
    logic pwm_en;
    logic pin_en;
    logic lvl_b;
    logic lvl_a;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  // low sel_i+1 bits set, capped at DIV_W
  always_comb begin
    mask = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (i <= int'(sel_i)) mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  assign tick_o = ((div_q & mask) == mask);
endmodule

// File: rtl/pwm_cmp_reg.sv
module pwm_cmp_reg #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  val_o,
  output logic              armed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_o   <= '1;
      armed_o <= 1'b1;
    end else if (wr_hi_i) begin
      val_o[CNT_W-1:DATA_W] <= wdata_i;
      armed_o               <= 1'b0;
    end else if (wr_lo_i) begin
      val_o[DATA_W-1:0] <= wdata_i;
      armed_o           <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int unsigned CNT_W = 16,
  localparam logic [CNT_W-1:0] RELOAD = {CNT_W{1'b1}} - CNT_W'(3)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pwm_en_i,
  input  logic             lvl_a_i,
  input  logic             lvl_b_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic             arm_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  input  logic             arm_b_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wave_o,
  output logic             period_hit_o
);
  logic hit_a, hit_b;

  assign hit_a = pwm_en_i && arm_a_i && (cnt_o == cmp_a_i);
  assign hit_b = pwm_en_i && arm_b_i && (cnt_o == cmp_b_i);
  assign period_hit_o = tick_i && hit_b;

  // compare-B wins when both match the same count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= RELOAD;
      wave_o <= 1'b0;
    end else if (tick_i) begin
      if (hit_b) begin
        cnt_o  <= RELOAD;
        wave_o <= lvl_b_i;
      end else begin
        cnt_o <= cnt_o + 1'b1;
        if (hit_a) wave_o <= lvl_a_i;
      end
    end
  end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              int_mask_i,
  output logic              pwm_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = 2 * DATA_W;
  localparam int unsigned SEL_W = 2;
  localparam int unsigned N_CMP = 2;

  ctrl_t            ctrl_q;
  logic [SEL_W-1:0] clk_sel_q;
  logic             cap_flag_q;
  logic             clr_arm_q;
  logic [CNT_W-1:0] cap_q;

  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             wave;
  logic             period_hit;
  logic [CNT_W-1:0] cmp_val [N_CMP];
  logic             cmp_arm [N_CMP];

  logic wr_ctrl, wr_clk, rd_stat, rd_cap;
  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign wr_clk  = wr_en_i && (addr_i == A_CLK);
  assign rd_stat = rd_en_i && (addr_i == A_STAT);
  assign rd_cap  = rd_en_i && (addr_i == A_CAPL);

  pwm_prescaler #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (clk_sel_q),
    .tick_o (tick)
  );

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(int'(A_C1H) + 2 * g);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(int'(A_C1L) + 2 * g);
    pwm_cmp_reg #(.DATA_W(DATA_W)) u_cmp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_hi_i (wr_en_i && (addr_i == HI_A)),
      .wr_lo_i (wr_en_i && (addr_i == LO_A)),
      .wdata_i (wdata_i),
      .val_o   (cmp_val[g]),
      .armed_o (cmp_arm[g])
    );
  end

  // one-pulse bit is stored only; PWM dominates when both are set
  pwm_core #(.CNT_W(CNT_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .pwm_en_i     (ctrl_q.pwm_en),
    .lvl_a_i      (ctrl_q.lvl_a),
    .lvl_b_i      (ctrl_q.lvl_b),
    .cmp_a_i      (cmp_val[0]),
    .arm_a_i      (cmp_arm[0]),
    .cmp_b_i      (cmp_val[1]),
    .arm_b_i      (cmp_arm[1]),
    .cnt_o        (cnt),
    .wave_o       (wave),
    .period_hit_o (period_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      clk_sel_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q    <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_clk)  clk_sel_q <= wdata_i[SEL_W-1:0];
    end
  end

  // flag set beats clear; clear needs a prior status read that saw it set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_flag_q <= 1'b0;
      clr_arm_q  <= 1'b0;
      cap_q      <= '0;
    end else begin
      if (period_hit) cap_q <= cnt;
      if (period_hit)                  cap_flag_q <= 1'b1;
      else if (rd_cap && clr_arm_q)    cap_flag_q <= 1'b0;
      if (rd_stat && cap_flag_q)       clr_arm_q  <= 1'b1;
      else if (rd_cap)                 clr_arm_q  <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      A_CLK:   rdata_o = {{(DATA_W-SEL_W){1'b0}}, clk_sel_q};
      A_STAT:  rdata_o = {{(DATA_W-1){1'b0}}, cap_flag_q};
      A_C1H:   rdata_o = cmp_val[0][CNT_W-1:DATA_W];
      A_C1L:   rdata_o = cmp_val[0][DATA_W-1:0];
      A_C2H:   rdata_o = cmp_val[1][CNT_W-1:DATA_W];
      A_C2L:   rdata_o = cmp_val[1][DATA_W-1:0];
      A_CAPL:  rdata_o = cap_q[DATA_W-1:0];
      default: rdata_o = '0;
    endcase
  end

  assign pwm_o = ctrl_q.pin_en && wave;
  assign irq_o = cap_flag_q && ctrl_q.cap_ie && !int_mask_i;
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cmp_b_i,
  input logic             arm_b_i,
  input logic             pwm_en_i,
  input logic             flag_i,
  input logic             wr_en_i,
  input logic             pwm_o
);
  localparam logic [CNT_W-1:0] RELOAD_V = {CNT_W{1'b1}} - CNT_W'(3);

  // R4
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && pwm_en_i && arm_b_i && cnt_i == cmp_b_i) |=> (cnt_i == RELOAD_V));

  // R8
  inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !arm_b_i) |=> (cnt_i == $past(cnt_i) + 1'b1));

  // R3
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);

  // R9
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $past(tick_i && pwm_en_i));

  // R13
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwm_en_i && !wr_en_i) |=> $stable(pwm_o));
endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick),
  .cnt_i    (cnt),
  .cmp_b_i  (cmp_val[1]),
  .arm_b_i  (cmp_arm[1]),
  .pwm_en_i (ctrl_q.pwm_en),
  .flag_i   (cap_flag_q),
  .wr_en_i  (wr_en_i),
  .pwm_o    (pwm_o)
);

// File: tb/pwm_timer_tb.sv
module pwm_timer_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic       int_mask = 1'b1;
  logic       pwm;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pwm_timer u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .addr_i     (addr),
    .wr_en_i    (wr_en),
    .wdata_i    (wdata),
    .rd_en_i    (rd_en),
    .rdata_o    (rdata),
    .int_mask_i (int_mask),
    .pwm_o      (pwm),
    .irq_o      (irq)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    addr = 3'(a); wdata = 8'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    addr = 3'(a); rd_en = 1'b1;
    #1 d = int'(rdata);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic int presc_of(int sel);
    return (sel == 0) ? 2 : (sel == 1) ? 4 : 8;
  endfunction

  function automatic int exp_period(int c2, int sel);
    return (c2 + 5) * presc_of(sel);
  endfunction

  function automatic int exp_high(int c1, int c2, int sel);
    return (c2 - c1) * presc_of(sel);
  endfunction

  task automatic wait_lvl(logic v, string req);
    int k = 0;
    while (pwm !== v && k < 20000) begin @(negedge clk); k++; end
    if (k >= 20000) check(req, 0, 1);
  endtask

  task automatic wait_fall(string req);
    wait_lvl(1'b1, req);
    wait_lvl(1'b0, req);
  endtask

  task automatic measure(output int hi, output int per);
    wait_lvl(1'b0, "measure");
    wait_lvl(1'b1, "measure");
    hi = 0;
    while (pwm === 1'b1 && hi < 20000) begin @(negedge clk); hi++; end
    per = hi;
    while (pwm === 1'b0 && per < 40000) begin @(negedge clk); per++; end
  endtask

  task automatic observe(int n, output int rises, output int falls, output int highs);
    logic prev;
    rises = 0; falls = 0; highs = 0;
    prev = pwm;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm && !prev) rises++;
      if (!pwm && prev) falls++;
      if (pwm) highs++;
      prev = pwm;
    end
  endtask

  task automatic cfg(int c1, int c2, int sel);
    wr(3, c1 >> 8); wr(4, c1 & 8'hFF);
    wr(5, c2 >> 8); wr(6, c2 & 8'hFF);
    wr(1, sel);
  endtask

  initial begin
    #2_000_000;
    check("watchdog", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int d, hi, per, r, f, h;
    int c1, c2, sel;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    check("R1 pwm_o", int'(pwm), 0);
    check("R1 irq_o", int'(irq), 0);
    rd(0, d); check("R1 ctrl", d, 0);
    rd(1, d); check("R1 clk", d, 0);
    rd(2, d); check("R1 status", d, 0);

    // R2 readback, first directed config
    cfg(10, 30, 0);
    wr(0, 8'h0D);
    rd(4, d); check("R2 cmpA low", d, 10);
    rd(6, d); check("R2 cmpB low", d, 30);
    rd(3, d); check("R2 cmpA high", d, 0);
    rd(0, d); check("R2 ctrl", d, 8'h0D);
    measure(hi, per); measure(hi, per);
    check("R4 period", per, exp_period(30, 0));
    check("R5 high", hi, exp_high(10, 30, 0));

    // R3 R4 R5 random compare and prescale settings
    for (int it = 0; it < 6; it++) begin
      c1 = 4 + int'($urandom_range(0, 20));
      c2 = c1 + 2 + int'($urandom_range(0, 40));
      sel = int'($urandom_range(0, 3));
      wait_fall("R4 sync");
      cfg(c1, c2, sel);
      measure(hi, per); measure(hi, per);
      check("R3,R4 period", per, exp_period(c2, sel));
      check("R5 high", hi, exp_high(c1, c2, sel));
    end

    // R12 one-pulse together with PWM
    wait_fall("R12 sync");
    wr(0, 8'h1D);
    measure(hi, per); measure(hi, per);
    check("R12 period", per, exp_period(c2, sel));
    wr(0, 8'h0D);

    wait_fall("R4 sync");
    cfg(6, 20, 0);
    measure(hi, per); measure(hi, per);
    check("R4 period", per, exp_period(20, 0));

    // R6 equal levels
    wr(0, 8'h0F);
    repeat (60) @(negedge clk);
    observe(200, r, f, h);
    check("R6 edges high", r + f, 0);
    check("R6 level high", h, 200);
    wr(0, 8'h0C);
    repeat (60) @(negedge clk);
    observe(200, r, f, h);
    check("R6 edges low", r + f, 0);
    check("R6 level low", h, 0);

    // R7 pin disabled
    wr(0, 8'h09);
    observe(200, r, f, h);
    check("R7 pin low", h, 0);
    wr(0, 8'h0D);

    // R8 high-byte write inhibits compare-B until low byte
    wait_fall("R8 sync");
    wr(5, 0);
    observe(200, r, f, h);
    check("R8 no reload", f, 0);
    wr(6, 200);
    measure(hi, per);
    check("R8 new period", per, exp_period(200, 0));
    check("R8 new high", hi, exp_high(6, 200, 0));

    wait_fall("R9 sync");
    cfg(6, 20, 0);

    // R9 R10 R11 capture flag
    wr(0, 8'h2D);
    int_mask = 1'b1;
    wait_fall("R9 sync");
    wr(0, 8'h25);
    check("R10 masked", int'(irq), 0);
    int_mask = 1'b0;
    @(negedge clk);
    check("R10 unmasked", int'(irq), 1);
    rd(7, d); check("R9 capture low", d, 20);
    check("R11 kept without status read", int'(irq), 1);
    wr(0, 8'h05);
    check("R10 ie off", int'(irq), 0);
    wr(0, 8'h25);
    rd(2, d); check("R9 status flag", d, 1);
    rd(7, d);
    check("R11 irq cleared", int'(irq), 0);
    rd(2, d); check("R11 status cleared", d, 0);

    // R13 PWM off
    observe(300, r, f, h);
    check("R13 pin steady", r + f, 0);
    check("R13 no flag", int'(irq), 0);
    rd(2, d); check("R13 status", d, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule